// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual address into a physical address by fetching one page table entry from physical memory. A requester presents a virtual address together with a read/write flag. The walker combines the page table base register with the virtual page number to get the entry's address. It issues exactly one word read on a simple request/response memory port. It then decodes the returned entry and reports either the translated address or a fault code.

Pages and frames are both 1 KB, so the low 10 address bits pass through untouched. The walker distinguishes two kinds of failure. The first is a missing mapping, meaning the valid bit is clear; software must bring the page in. The second is a rights violation on a page that is present. Resolving a fault is left to software; the walker only reports it. One translation is in flight at a time. Software loads the base register through a write strobe, and the new value applies from the next accepted request.

Top module: `pt_walker`

## Requirements
- R1: After reset `busy_o`, `mem_req_o` and `rsp_valid_o` are low, and the base register holds `RESET_BASE` (default 0).
- R2: The entry address on `mem_addr_o` equals base + (VPN << 2), modulo 2^PA_W, where VPN = `req_vaddr_i[VA_W-1:10]`.
- R3: A request is accepted on a clock edge where `req_valid_i` is high and no walk is waiting on memory. `mem_req_o` rises in the next cycle. It stays high with a stable `mem_addr_o` until the edge that samples `mem_rvalid_i` high. Exactly one read is issued per request.
- R4: The entry layout is fixed as follows. Bit 0 is valid. Bit 1 grants read. Bit 2 grants write. Bits [31:10] hold the frame number. Bits [9:3] are ignored.
- R5: When the valid bit is clear, the result is fault code 2'b01 (not present) and `rsp_paddr_o` is 0, whatever the rights bits hold.
- R6: When the entry is valid but the access lacks its right, the result is fault code 2'b10 (protection) and `rsp_paddr_o` is 0. A write needs bit 2; a read needs bit 1.
- R7: On success the fault code is 2'b00 and `rsp_paddr_o` is {frame, `req_vaddr_i[9:0]`}, formed by concatenation.
- R8: `rsp_valid_o` is high for exactly one cycle, the cycle after the edge that sampled the memory response. `busy_o` is low in that cycle.
- R9: A write on `ptbr_we_i` updates the base register at the clock edge. The walk in flight keeps the entry address it already formed. The next accepted request uses the new base.
- R10: `req_valid_i` has no effect while a walk waits on memory. No second read follows, and the address of the current read does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ptbr_we_i | input | 1 | Base register write strobe |
| ptbr_wdata_i | input | PA_W | New base register value |
| req_valid_i | input | 1 | Translation request |
| req_vaddr_i | input | VA_W | Virtual address to translate |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | Entry read request, held until response |
| mem_addr_o | output | PA_W | Entry byte address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | PTE_W | Entry read data |
| rsp_valid_o | output | 1 | Result valid, single cycle |
| rsp_fault_o | output | 2 | 00 ok, 01 not present, 10 protection |
| rsp_paddr_o | output | PA_W | Physical address, 0 on fault |

## Verification
A corrupted walk state can show up in three ways. The read may be held past the response, so `mem_req_o` stays high in the cycle where `rsp_valid_o` should appear. A response may not be a single-cycle pulse. A second read may appear without a new request. Each of these is visible within one cycle of the memory response. A wrong latched address or access flag is visible one cycle after acceptance on `mem_addr_o`, or in the result cycle on the fault code and the offset bits of `rsp_paddr_o`. Directed walks cover several memory latencies, address wrap-around, every rights combination, and base writes and extra requests placed in the middle of a walk.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [1:0] {
    FLT_NONE    = 2'b00,
    FLT_ABSENT  = 2'b01,
    FLT_PROTECT = 2'b10
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_WAIT = 2'b01,
    ST_DONE = 2'b10
  } walk_st_e;

  localparam int unsigned PTE_V_BIT = 0;
  localparam int unsigned PTE_R_BIT = 1;
  localparam int unsigned PTE_W_BIT = 2;
endpackage

// File: rtl/pt_walker_base.sv
module pt_walker_base #(
  parameter int unsigned VA_W       = 32,
  parameter int unsigned PA_W       = 32,
  parameter int unsigned OFF_W      = 10,
  parameter logic [PA_W-1:0] RESET_BASE = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [PA_W-1:0] wdata_i,
  input  logic [VA_W-1:0] vaddr_i,
  output logic [PA_W-1:0] entry_addr_o
);
  localparam int unsigned VPN_W = VA_W - OFF_W;

  logic [PA_W-1:0]  base_q;
  logic [VPN_W-1:0] vpn;
  logic [PA_W-1:0]  idx_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   base_q <= RESET_BASE;
    else if (we_i) base_q <= wdata_i;
  end

  assign vpn     = vaddr_i[VA_W-1:OFF_W];
  assign idx_ext = PA_W'(vpn);
  // 4-byte entries
  assign entry_addr_o = base_q + (idx_ext << 2);
endmodule

// File: rtl/pt_walker_ctrl.sv
module pt_walker_ctrl
  import pt_walker_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic mem_rvalid_i,
  output logic accept_o,
  output logic capture_o,
  output logic mem_req_o,
  output logic rsp_valid_o,
  output logic busy_o
);
  walk_st_e st_q, st_d;

  assign accept_o  = req_valid_i && (st_q != ST_WAIT);
  assign capture_o = (st_q == ST_WAIT) && mem_rvalid_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept_o) st_d = ST_WAIT;
      ST_WAIT: if (mem_rvalid_i) st_d = ST_DONE;
      ST_DONE: st_d = accept_o ? ST_WAIT : ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign mem_req_o   = (st_q == ST_WAIT);
  assign rsp_valid_o = (st_q == ST_DONE);
  assign busy_o      = (st_q == ST_WAIT);
endmodule

// File: rtl/pt_walker_resolve.sv
module pt_walker_resolve
  import pt_walker_pkg::*;
#(
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 10
) (
  input  logic                  ent_valid_i,
  input  logic                  ent_rd_i,
  input  logic                  ent_wr_i,
  input  logic [PA_W-OFF_W-1:0] ent_frame_i,
  input  logic [OFF_W-1:0]      offset_i,
  input  logic                  write_i,
  output fault_e                fault_o,
  output logic [PA_W-1:0]       paddr_o
);
  logic allowed;

  assign allowed = write_i ? ent_wr_i : ent_rd_i;

  always_comb begin
    if (!ent_valid_i)  fault_o = FLT_ABSENT;
    else if (!allowed) fault_o = FLT_PROTECT;
    else               fault_o = FLT_NONE;
  end

  assign paddr_o = (fault_o == FLT_NONE) ? {ent_frame_i, offset_i} : '0;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 10,
  parameter int unsigned PTE_W = 32,
  parameter logic [PA_W-1:0] RESET_BASE = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ptbr_we_i,
  input  logic [PA_W-1:0]  ptbr_wdata_i,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             req_write_i,
  output logic             busy_o,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [PTE_W-1:0] mem_rdata_i,
  output logic             rsp_valid_o,
  output logic [1:0]       rsp_fault_o,
  output logic [PA_W-1:0]  rsp_paddr_o
);
  localparam int unsigned FRAME_W = PA_W - OFF_W;

  logic               accept, capture;
  logic [PA_W-1:0]    entry_addr, addr_q;
  logic [OFF_W-1:0]   off_q;
  logic               write_q;
  logic               ev_q, er_q, ew_q;
  logic [FRAME_W-1:0] frame_q;
  fault_e             fault;
  logic [PA_W-1:0]    paddr;
  logic               unused_pte;

  assign unused_pte = ^mem_rdata_i[OFF_W-1:PTE_W_BIT+1];

  pt_walker_base #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .RESET_BASE(RESET_BASE)
  ) u_base (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(ptbr_we_i), .wdata_i(ptbr_wdata_i),
    .vaddr_i(req_vaddr_i), .entry_addr_o(entry_addr)
  );

  pt_walker_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
    .mem_rvalid_i(mem_rvalid_i), .accept_o(accept), .capture_o(capture),
    .mem_req_o(mem_req_o), .rsp_valid_o(rsp_valid_o), .busy_o(busy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      off_q   <= '0;
      write_q <= 1'b0;
    end else if (accept) begin
      addr_q  <= entry_addr;
      off_q   <= req_vaddr_i[OFF_W-1:0];
      write_q <= req_write_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_q    <= 1'b0;
      er_q    <= 1'b0;
      ew_q    <= 1'b0;
      frame_q <= '0;
    end else if (capture) begin
      ev_q    <= mem_rdata_i[PTE_V_BIT];
      er_q    <= mem_rdata_i[PTE_R_BIT];
      ew_q    <= mem_rdata_i[PTE_W_BIT];
      frame_q <= mem_rdata_i[OFF_W +: FRAME_W];
    end
  end

  pt_walker_resolve #(.PA_W(PA_W), .OFF_W(OFF_W)) u_resolve (
    .ent_valid_i(ev_q), .ent_rd_i(er_q), .ent_wr_i(ew_q), .ent_frame_i(frame_q),
    .offset_i(off_q), .write_i(write_q), .fault_o(fault), .paddr_o(paddr)
  );

  assign mem_addr_o  = addr_q;
  assign rsp_fault_o = rsp_valid_o ? fault : FLT_NONE;
  assign rsp_paddr_o = rsp_valid_o ? paddr : '0;
endmodule

// File: rtl/pt_walker_sva.sv
module pt_walker_sva #(
  parameter int unsigned PA_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            busy_o,
  input logic            mem_req_o,
  input logic [PA_W-1:0] mem_addr_o,
  input logic            mem_rvalid_i,
  input logic            rsp_valid_o,
  input logic [1:0]      rsp_fault_o,
  input logic [PA_W-1:0] rsp_paddr_o
);
  assert_req_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));

  assert_accept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_req_o && req_valid_i |=> mem_req_o);

  assert_rsp_after_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_rvalid_i |=> rsp_valid_o && !busy_o && !mem_req_o);

  assert_rsp_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !$past(rsp_valid_o) || $past(req_valid_i));

  assert_fault_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o != 2'b11);

  assert_fault_no_pa_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o != 2'b00 |-> rsp_paddr_o == '0);

  assert_busy_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == mem_req_o);
endmodule

bind pt_walker pt_walker_sva #(.PA_W(PA_W)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .busy_o(busy_o),
  .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rvalid_i(mem_rvalid_i),
  .rsp_valid_o(rsp_valid_o), .rsp_fault_o(rsp_fault_o), .rsp_paddr_o(rsp_paddr_o)
);

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ptbr_we_i = 1'b0;
  logic [31:0] ptbr_wdata_i = '0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_vaddr_i = '0;
  logic        req_write_i = 1'b0;
  logic        busy_o, mem_req_o, mem_rvalid_i, rsp_valid_o;
  logic [31:0] mem_addr_o, mem_rdata_i, rsp_paddr_o;
  logic [1:0]  rsp_fault_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  initial begin
    mem_rvalid_i = 1'b0;
    mem_rdata_i  = '0;
  end

  always #5 clk_i = ~clk_i;

  pt_walker u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ptbr_we_i(ptbr_we_i), .ptbr_wdata_i(ptbr_wdata_i),
    .req_valid_i(req_valid_i), .req_vaddr_i(req_vaddr_i), .req_write_i(req_write_i),
    .busy_o(busy_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i), .rsp_valid_o(rsp_valid_o),
    .rsp_fault_o(rsp_fault_o), .rsp_paddr_o(rsp_paddr_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ent_addr(input logic [31:0] base, input logic [31:0] va);
    return base + ((va >> 10) << 2);
  endfunction

  task automatic set_base(input logic [31:0] b);
    ptbr_we_i = 1'b1; ptbr_wdata_i = b;
    @(negedge clk_i);
    ptbr_we_i = 1'b0;
  endtask

  // One full walk; entry returned after lat idle cycles of waiting
  task automatic walk(input string tag, input logic [31:0] base, input logic [31:0] va,
                      input logic wr, input logic [31:0] pte, input int lat,
                      input logic [1:0] exp_f, input logic [31:0] exp_pa);
    req_valid_i = 1'b1; req_vaddr_i = va; req_write_i = wr;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check({tag, " R3 mem_req"}, 32'(mem_req_o), 32'd1);
    check({tag, " R2 entry addr"}, mem_addr_o, ent_addr(base, va));
    for (int i = 0; i < lat; i++) begin
      @(negedge clk_i);
      check({tag, " R3 held"}, 32'(mem_req_o), 32'd1);
    end
    mem_rvalid_i = 1'b1; mem_rdata_i = pte;
    @(negedge clk_i);
    mem_rvalid_i = 1'b0; mem_rdata_i = 32'hDEAD_BEEF;
    check({tag, " R8 rsp_valid"}, 32'(rsp_valid_o), 32'd1);
    check({tag, " R8 busy low"}, 32'(busy_o), 32'd0);
    check({tag, " R3 req dropped"}, 32'(mem_req_o), 32'd0);
    check({tag, " fault"}, 32'(rsp_fault_o), 32'(exp_f));
    check({tag, " paddr"}, rsp_paddr_o, exp_pa);
    @(negedge clk_i);
    check({tag, " R8 single pulse"}, 32'(rsp_valid_o), 32'd0);
    check({tag, " R3 no extra read"}, 32'(mem_req_o), 32'd0);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R1 busy", 32'(busy_o), 32'd0);
    check("R1 mem_req", 32'(mem_req_o), 32'd0);
    check("R1 rsp_valid", 32'(rsp_valid_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    walk("R1 base zero", 32'h0, 32'h0000_0C04, 1'b0, {22'h1, 7'h0, 3'b011}, 0,
         2'b00, {22'h1, 10'h004});
  endtask

  task automatic t_success();
    logic [31:0] pte;
    set_base(32'h0001_0000);
    pte = {22'h025A5, 7'h7F, 3'b011};
    walk("R7 read ok", 32'h0001_0000, 32'h0040_2ABC, 1'b0, pte, 2, 2'b00,
         {pte[31:10], 10'h2BC});
    pte = {22'h3FFFF, 7'h00, 3'b111};
    walk("R7 write ok", 32'h0001_0000, 32'h1234_57FF, 1'b1, pte, 5, 2'b00,
         {pte[31:10], 10'h3FF});
    set_base(32'hFFFF_0000);
    pte = {22'h00ABC, 7'h55, 3'b011};
    walk("R2 wrap", 32'hFFFF_0000, 32'hFFFF_FFFF, 1'b0, pte, 1, 2'b00,
         {pte[31:10], 10'h3FF});
  endtask

  task automatic t_faults();
    set_base(32'h0000_8000);
    walk("R6 write to read-only", 32'h0000_8000, 32'h0000_5123, 1'b1,
         {22'h00777, 7'h00, 3'b011}, 1, 2'b10, 32'h0);
    walk("R6 read w/o read right", 32'h0000_8000, 32'h0000_5123, 1'b0,
         {22'h00777, 7'h00, 3'b101}, 0, 2'b10, 32'h0);
    walk("R5 absent rw page", 32'h0000_8000, 32'h0080_0010, 1'b0,
         {22'h00123, 7'h00, 3'b110}, 3, 2'b01, 32'h0);
    walk("R5 absent write", 32'h0000_8000, 32'h0080_0010, 1'b1,
         {22'h00123, 7'h7F, 3'b000}, 0, 2'b01, 32'h0);
    walk("R4 ignored bits", 32'h0000_8000, 32'h0000_0001, 1'b0,
         {22'h00321, 7'h7F, 3'b011}, 0, 2'b00, {22'h00321, 10'h001});
  endtask

  task automatic t_base_mid_walk();
    set_base(32'h0002_0000);
    req_valid_i = 1'b1; req_vaddr_i = 32'h0000_1400; req_write_i = 1'b0;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    ptbr_we_i = 1'b1; ptbr_wdata_i = 32'h0030_0000;
    @(negedge clk_i);
    ptbr_we_i = 1'b0;
    check("R9 inflight addr kept", mem_addr_o, ent_addr(32'h0002_0000, 32'h0000_1400));
    mem_rvalid_i = 1'b1; mem_rdata_i = {22'h5, 7'h0, 3'b011};
    @(negedge clk_i);
    mem_rvalid_i = 1'b0;
    check("R9 inflight result", rsp_paddr_o, {22'h5, 10'h000});
    @(negedge clk_i);
    walk("R9 new base used", 32'h0030_0000, 32'h0000_1400, 1'b0,
         {22'h6, 7'h0, 3'b011}, 0, 2'b00, {22'h6, 10'h000});
  endtask

  task automatic t_req_while_busy();
    set_base(32'h0000_4000);
    req_valid_i = 1'b1; req_vaddr_i = 32'h0000_0800; req_write_i = 1'b0;
    @(negedge clk_i);
    req_vaddr_i = 32'h7777_7000; req_write_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check("R10 addr unchanged", mem_addr_o, ent_addr(32'h0000_4000, 32'h0000_0800));
    mem_rvalid_i = 1'b1; mem_rdata_i = {22'h9, 7'h0, 3'b011};
    @(negedge clk_i);
    mem_rvalid_i = 1'b0;
    check("R10 first result kept", rsp_paddr_o, {22'h9, 10'h000});
    check("R10 first fault", 32'(rsp_fault_o), 32'd0);
    @(negedge clk_i);
    check("R10 no second read", 32'(mem_req_o), 32'd0);
    check("R10 idle", 32'(busy_o), 32'd0);
  endtask

  initial begin
    @(negedge clk_i);
    t_reset();
    t_success();
    t_faults();
    t_base_mid_walk();
    t_req_while_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule